// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes into an asynchronous serial character on a single output line. A byte arrives over a valid/ready handshake. The block then drives a low start bit and 5 to 8 data bits, least significant bit first. An optional parity bit follows, and then a high stop interval. A packed 7-bit format control input sets the word length, the stop length, the parity mode and a break request. Bit timing comes from a one-cycle `tick` pulse that runs at 16 times the bit rate. The block generates no baud rate of its own, so the stop interval can be one bit, one and a half bits or two bits long.

The format is captured on the clock edge that accepts a byte. Any change on the control input during a character only applies to the next character. A break request drives the line low until the request is removed. If a character is in flight when the request arrives, the break starts after that character ends. A transmit-disable input blocks new bytes. It does not cut short a character that is already being sent.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no character or break is active, `txd` is 1. After reset, `in_ready` is 1 as long as `tx_disable` and `fmt_ctrl[6]` are both 0.
- R2: On the edge where `in_valid` and `in_ready` are both 1, the byte is accepted and `txd` goes to 0 for a start bit. The start bit lasts 16 `tick` pulses.
- R3: `fmt_ctrl[1:0]` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits are sent bit 0 first, each for 16 ticks. Unused upper bits of `in_data` are never sent.
- R4: When `fmt_ctrl[3]` is 1 and `fmt_ctrl[5]` is 0, a 16-tick parity bit follows the data. With `fmt_ctrl[4]`=1 the parity is even, so data plus parity has an even count of ones. With `fmt_ctrl[4]`=0 the parity is odd.
- R5: When `fmt_ctrl[3]` and `fmt_ctrl[5]` are both 1, the parity bit is fixed at the value of `fmt_ctrl[4]`, whatever the data. When `fmt_ctrl[3]` is 0, no parity bit is sent.
- R6: When `fmt_ctrl[2]` is 0, the stop interval is high for 16 ticks.
- R7: When `fmt_ctrl[2]` is 1, the stop interval is high for 24 ticks with 5-bit words and for 32 ticks with all other word lengths.
- R8: When `fmt_ctrl[6]` is 1 and no character is active, `txd` is held at 0 and `in_ready` is 0. One cycle after the bit clears, `txd` returns to 1. A request raised during a character takes effect only after that character's stop interval has ended.
- R9: While `tx_disable` is 1, `in_ready` is 0. A character already started still completes unchanged.
- R10: `in_ready` is 1 only while no character or break is active. A byte presented during a character waits and is sent afterwards.
- R11: Changes to `fmt_ctrl[5:0]` after a byte has been accepted do not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_disable | input | 1 | Blocks acceptance of new bytes |
| fmt_ctrl | input | 7 | Format control: [1:0] word length, [2] long stop, [3] parity enable, [4] even/mark, [5] fixed parity, [6] break |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block can accept a byte this cycle |
| txd | output | 1 | Serial line, idles high |

## Verification
The hardest case is a control change that lands while a character is already on the line. This covers a new format arriving mid-character and a break request arriving mid-character. In both cases the visible result depends on the block ignoring the live control input until the right moment. The stimulus starts a character and then rewrites `fmt_ctrl` partway through the data bits. The reference model keeps its own captured copy of the character as a queue of timed line segments. Any early use of the new format shows up as a cycle-exact mismatch on `txd`. The tick pulse arrives only every third clock, so tick counting is separated from clock counting.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WLEN_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK
  } tx_state_e;

  typedef enum logic [1:0] {
    STOP_ONE,
    STOP_ONE_HALF,
    STOP_TWO
  } stop_len_e;

  typedef struct packed {
    logic [WLEN_W-1:0] nbits;
    logic              par_en;
    logic              par_val;
    stop_len_e         stop_sel;
  } frame_cfg_t;

endpackage

// File: rtl/tx_fmt_decode.sv
module tx_fmt_decode
  import uart_tx_pkg::*;
(
  input  logic [5:0]        fmt,
  input  logic [BYTE_W-1:0] data,
  output frame_cfg_t        cfg
);

  logic [WLEN_W-1:0] nbits;
  logic [BYTE_W-1:0] masked;
  logic              ones_odd;
  logic              par_calc;

  assign nbits = WLEN_W'(5) + {2'b00, fmt[1:0]};

  genvar gi;
  generate
    for (gi = 0; gi < BYTE_W; gi++) begin : g_mask
      assign masked[gi] = data[gi] & (WLEN_W'(gi) < nbits);
    end
  endgenerate

  assign ones_odd = ^masked;
  // even select: parity bit equals odd-ones flag so total is even
  assign par_calc = fmt[4] ? ones_odd : ~ones_odd;

  always_comb begin
    cfg.nbits   = nbits;
    cfg.par_en  = fmt[3];
    cfg.par_val = fmt[5] ? fmt[4] : par_calc;
    if (!fmt[2])
      cfg.stop_sel = STOP_ONE;
    else if (fmt[1:0] == 2'b00)
      cfg.stop_sel = STOP_ONE_HALF;
    else
      cfg.stop_sel = STOP_TWO;
  end

endmodule

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt == len - CNT_W'(1));
  assign done = tick && last && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    cnt < len); // R7

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_disable,
  input  logic [6:0]        fmt_ctrl,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd
);

  localparam int unsigned CNT_W      = $clog2(2 * OSR + 1);
  localparam int unsigned BIT_T      = OSR;
  localparam int unsigned STOP_HALF  = OSR + OSR / 2;
  localparam int unsigned STOP_TWO_T = 2 * OSR;
  localparam int unsigned IDX_W      = $clog2(BYTE_W);

  tx_state_e         state;
  frame_cfg_t        cfg_d, cfg_q;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  seg_len;
  logic              seg_done;
  logic              tmr_clr;
  logic              brk_req;
  logic              last_bit;

  assign brk_req = fmt_ctrl[6];

  tx_fmt_decode u_dec (
    .fmt  (fmt_ctrl[5:0]),
    .data (in_data),
    .cfg  (cfg_d)
  );

  always_comb begin
    seg_len = CNT_W'(BIT_T);
    if (state == ST_STOP) begin
      unique case (cfg_q.stop_sel)
        STOP_ONE_HALF: seg_len = CNT_W'(STOP_HALF);
        STOP_TWO:      seg_len = CNT_W'(STOP_TWO_T);
        default:       seg_len = CNT_W'(BIT_T);
      endcase
    end
  end

  assign tmr_clr = (state == ST_IDLE) || (state == ST_BREAK);

  tx_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (tmr_clr),
    .tick (tick),
    .len  (seg_len),
    .done (seg_done)
  );

  assign in_ready = (state == ST_IDLE) && !tx_disable && !brk_req;
  assign last_bit = ({1'b0, bit_idx} == cfg_q.nbits - WLEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      txd     <= 1'b1;
      shreg   <= '0;
      bit_idx <= '0;
      cfg_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (brk_req) begin
            state <= ST_BREAK;
            txd   <= 1'b0;
          end else if (in_valid && in_ready) begin
            state <= ST_START;
            txd   <= 1'b0;
            shreg <= in_data;
            cfg_q <= cfg_d;
          end
        end
        ST_START: begin
          if (seg_done) begin
            state   <= ST_DATA;
            txd     <= shreg[0];
            shreg   <= shreg >> 1;
            bit_idx <= '0;
          end
        end
        ST_DATA: begin
          if (seg_done) begin
            if (last_bit) begin
              if (cfg_q.par_en) begin
                state <= ST_PARITY;
                txd   <= cfg_q.par_val;
              end else begin
                state <= ST_STOP;
                txd   <= 1'b1;
              end
            end else begin
              txd     <= shreg[0];
              shreg   <= shreg >> 1;
              bit_idx <= bit_idx + IDX_W'(1);
            end
          end
        end
        ST_PARITY: begin
          if (seg_done) begin
            state <= ST_STOP;
            txd   <= 1'b1;
          end
        end
        ST_STOP: begin
          if (seg_done) begin
            state <= ST_IDLE;
            txd   <= 1'b1;
          end
        end
        ST_BREAK: begin
          if (!brk_req) begin
            state <= ST_IDLE;
            txd   <= 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          txd   <= 1'b1;
        end
      endcase
    end
  end

  AST_ACCEPT_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !txd); // R2

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> txd); // R1

  AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BREAK) |-> !txd); // R8

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (state == ST_IDLE && !tx_disable)); // R9

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_BREAK && $past(state) != ST_IDLE)
      |-> $stable(cfg_q)); // R11

  AST_SHORT_STOP_ONLY_5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.stop_sel == STOP_ONE_HALF) |-> (cfg_q.nbits == WLEN_W'(5))); // R7

endmodule

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb_top;

  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick;
  logic       tx_disable;
  logic [6:0] fmt_ctrl;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready;
  logic       txd;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  int    tdiv   = 0;
  bit    done_flag = 0;
  string extra_tag = "";

  int    q_lvl[$];
  int    q_len[$];
  string q_tag[$];
  bit    m_brk = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer #(.OSR(OSR)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .tx_disable (tx_disable),
    .fmt_ctrl   (fmt_ctrl),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .txd        (txd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // tick every third clock
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  task automatic push_seg(input int lvl, input int len, input string tag);
    q_lvl.push_back(lvl);
    q_len.push_back(len);
    q_tag.push_back({tag, extra_tag});
  endtask

  task automatic build_frame(input logic [7:0] d, input logic [6:0] c);
    int n;
    int ones;
    int p;
    n = 5 + int'(c[1:0]);
    ones = 0;
    push_seg(0, OSR, "R2");
    for (int i = 0; i < n; i++) begin
      push_seg(int'(d[i]), OSR, "R3");
      ones += int'(d[i]);
    end
    if (c[3]) begin
      if (c[5]) begin
        push_seg(int'(c[4]), OSR, "R5");
      end else begin
        p = c[4] ? (ones % 2) : 1 - (ones % 2);
        push_seg(p, OSR, "R4");
      end
    end
    if (!c[2])       push_seg(1, OSR, "R6");
    else if (n == 5) push_seg(1, OSR + OSR / 2, "R7");
    else             push_seg(1, 2 * OSR, "R7");
  endtask

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      q_lvl.delete(); q_len.delete(); q_tag.delete();
      m_brk = 0;
    end else if (q_lvl.size() > 0) begin
      if (tick) begin
        q_len[0] = q_len[0] - 1;
        if (q_len[0] == 0) begin
          void'(q_lvl.pop_front());
          void'(q_len.pop_front());
          void'(q_tag.pop_front());
        end
      end
    end else if (m_brk) begin
      if (!fmt_ctrl[6]) m_brk = 0;
    end else if (fmt_ctrl[6]) begin
      m_brk = 1;
    end else if (in_valid && !tx_disable) begin
      build_frame(in_data, fmt_ctrl);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int    exp_lvl;
    int    exp_rdy;
    string tag;
    if (!rst) begin
      if (q_lvl.size() > 0) begin
        exp_lvl = q_lvl[0];
        tag = q_tag[0];
      end else begin
        exp_lvl = m_brk ? 0 : 1;
        tag = m_brk ? "R8" : "R1";
      end
      exp_rdy = (q_lvl.size() == 0 && !m_brk && !tx_disable && !fmt_ctrl[6]) ? 1 : 0;
      chk(int'(txd) == exp_lvl, tag, int'(txd), exp_lvl);
      chk(int'(in_ready) == exp_rdy, "R10 ready", int'(in_ready), exp_rdy);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      summary();
    end
  end

  task automatic send(input logic [7:0] d, input logic [6:0] c);
    bit got;
    fmt_ctrl = c;
    in_data  = d;
    in_valid = 1'b1;
    got = 0;
    while (!got) begin
      @(negedge clk);
      got = in_ready;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (q_lvl.size() != 0 || m_brk) @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int seed;
    seed = 17;
    rst = 1'b1; tick = 1'b0; tx_disable = 1'b0;
    fmt_ctrl = '0; in_data = '0; in_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset line", int'(txd), 1);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);

    // R3 R4 R5 R6 R7: every format combination, back to back (R10)
    for (int c = 0; c < 64; c++) begin
      seed = seed * 1103515245 + 12345;
      send(8'(seed >>> 9), 7'(c));
    end
    wait_idle();

    // R11: format rewritten mid-character
    extra_tag = " R11";
    send(8'hB5, 7'h1B);
    repeat (100) @(posedge clk);
    #1 fmt_ctrl = 7'h24;
    wait_idle();
    extra_tag = "";

    // R9: disable blocks acceptance while idle
    tx_disable = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h3C;
    repeat (60) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 disabled idle", int'(in_ready), 0);
    end
    @(posedge clk);
    #1 in_valid = 1'b0; tx_disable = 1'b0;

    // R9: disable raised mid-character, character completes
    extra_tag = " R9";
    send(8'h96, 7'h0F);
    repeat (40) @(posedge clk);
    #1 tx_disable = 1'b1;
    wait_idle();
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 after frame", int'(in_ready), 0);
    @(posedge clk);
    #1 tx_disable = 1'b0;
    extra_tag = "";

    // R8: break from idle
    fmt_ctrl = 7'h43;
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(txd == 1'b0, "R8 break low", int'(txd), 0);
    @(posedge clk);
    #1 fmt_ctrl = 7'h03;
    repeat (20) @(posedge clk);

    // R8: break requested during a character
    extra_tag = " R8";
    send(8'h5A, 7'h03);
    repeat (50) @(posedge clk);
    #1 fmt_ctrl = 7'h43;
    while (q_lvl.size() != 0) @(posedge clk);
    repeat (200) @(posedge clk);
    #1 fmt_ctrl = 7'h03;
    repeat (20) @(posedge clk);
    extra_tag = "";

    // R10: byte presented right after break, sent normally
    send(8'hE1, 7'h08);
    wait_idle();

    summary();
  end

endmodule